// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns a stream of bytes written by a host into asynchronous serial frames on a single output line. Writes go into an eight-entry first-in first-out store. Each time a frame slot opens, the transmitter takes the oldest byte and wraps it in a frame. The frame is a low start bit, the eight data bits least significant first, an optional parity bit, and one or two high stop bits. One bit goes out per baud tick. Baud-rate division happens outside the block, and only its one-cycle tick pulse comes in.

The host is paced by a service-request output. The request is raised while at least four slots are free and dropped once five or more are occupied. A host answering the request may therefore push four bytes blindly. After that it consults the space-available flag. A write that arrives while all slots are occupied is discarded and raises a sticky overflow flag, which the host clears with a pulse. When the store runs dry the line rests high after the last stop bit and stays high until more data arrives. The block works on its own, independently of any receiver.

Top module: `uart_tx_fifo`

## Requirements
- R1: While reset is active, and in the first cycle after it ends, the serial line is high, the service request is high, space-available is high and the overflow flag is low.
- R2: The store holds up to 8 bytes and sends them in write order. Space-available is low exactly when 8 bytes are held, and it updates in the cycle after the write or the frame load that changed the count.
- R3: A write while 8 bytes are held is discarded and sets the overflow flag in the next cycle. The flag then stays set until a cycle with the clear input high and no discarded write, after which it reads low. A discarded write wins over a clear in the same cycle.
- R4: A frame begins with one low start bit, followed by the 8 data bits least significant bit first. Each bit holds for exactly one baud-tick interval, and the line changes only in the cycle after a tick.
- R5: With parity enabled, one parity bit follows the data. With the parity-select input at 0 it makes the count of ones over data plus parity even; with it at 1 it makes that count odd. With parity disabled, no bit is inserted.
- R6: The frame ends with one high stop bit when the stop-select input is 0 and with two when it is 1.
- R7: The service request is high whenever 4 or more slots are free, and low whenever 5 or more slots are filled. It changes in the same cycle as the count it reflects.
- R8: With nothing queued, the line stays high after the final stop bit. A frame starts only on a tick that comes after the final stop bit has run a full interval, or on any tick while idle. When the store holds more data, the next frame follows on the tick that ends the previous frame, with no gap.
- R9: The parity and stop settings are taken when a frame is loaded; changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push request from the host |
| wr_data | input | 8 | Byte to push |
| baud_tick | input | 1 | One-cycle pulse marking each bit interval |
| parity_en | input | 1 | 1 inserts a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| ovf_clear | input | 1 | Clears the overflow flag |
| txd | output | 1 | Serial output line |
| svc_req | output | 1 | Service request for interrupt or DMA |
| space_avail | output | 1 | At least one slot is free |
| overflow | output | 1 | Sticky discarded-write flag |

## Verification
Every result of this block is registered once. A write, a clear or a tick at a clock edge shows up on txd, svc_req, space_avail and overflow right after that same edge, so each is due one cycle after the stimulus is applied. The bench drives inputs on the falling edge and applies its reference model after the rising edge. It then compares all four outputs on the next falling edge, half a period away from any edge where they change. Each serial-line mismatch is labelled by the part of the frame the model expects (start, data, parity, stop or idle), so framing, parity and idle faults are told apart.

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH        = 8,
  parameter int DATA_W       = 8,
  parameter int REQ_ON_FREE  = 4,
  parameter int REQ_OFF_FILL = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              two_stop,
  input  logic              ovf_clear,
  output logic              txd,
  output logic              svc_req,
  output logic              space_avail,
  output logic              overflow
);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count, count_nxt;
  logic [FRAME_W-1:0] sh, frame_load;
  logic [LEN_W-1:0]   bits_left, len_load;
  logic               push, pop, full, frame_done, par_bit;
  logic [DATA_W-1:0]  head;

  assign full       = (count == CNT_W'(DEPTH));
  assign push       = wr_en && !full;
  assign frame_done = (bits_left <= LEN_W'(1));
  assign pop        = baud_tick && frame_done && (count != '0);
  assign count_nxt  = count + CNT_W'(push) - CNT_W'(pop);
  assign head       = mem[rd_ptr];
  assign par_bit    = (^head) ^ parity_odd;
  assign frame_load = parity_en ? {2'b11, par_bit, head, 1'b0} : {3'b111, head, 1'b0};
  assign len_load   = LEN_W'(DATA_W + 2) + LEN_W'(parity_en) + LEN_W'(two_stop);

  assign txd         = sh[0];
  assign space_avail = !full;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '1;
      bits_left <= '0;
    end else if (baud_tick) begin
      if (!frame_done) begin
        sh        <= {1'b1, sh[FRAME_W-1:1]};
        bits_left <= bits_left - LEN_W'(1);
      end else if (count != '0) begin
        sh        <= frame_load;
        bits_left <= len_load;
      end else begin
        sh        <= '1;
        bits_left <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_req <= 1'b1;
    end else if (DEPTH - int'(count_nxt) >= REQ_ON_FREE) begin
      svc_req <= 1'b1;
    end else if (int'(count_nxt) >= REQ_OFF_FILL) begin
      svc_req <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              overflow <= 1'b0;
    else if (wr_en && full)  overflow <= 1'b1;
    else if (ovf_clear)      overflow <= 1'b0;
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !space_avail) |=> overflow);

  assert_line_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));

  assert_req_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (DEPTH - int'(count) >= REQ_ON_FREE) |-> svc_req);

  assert_req_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) >= REQ_OFF_FILL) |-> !svc_req);

  assert_start_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(baud_tick));

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_left == '0) |-> txd);
endmodule

// File: tb/test_uart_tx_fifo.sv
module test_uart_tx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, baud_tick = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic two_stop = 1'b0, ovf_clear = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, svc_req, space_avail, overflow;

  uart_tx_fifo i_uart_tx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .baud_tick(baud_tick), .parity_en(parity_en), .parity_odd(parity_odd),
    .two_stop(two_stop), .ovf_clear(ovf_clear), .txd(txd), .svc_req(svc_req),
    .space_avail(space_avail), .overflow(overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit finished = 0, ctx_r9 = 0;

  logic [7:0] mq [$];
  logic [11:0] fb;
  int flen = 0, pos = 0;
  bit busy = 0, m_pe = 0;
  bit m_ovf = 0, m_svc = 1;

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic logic exp_txd();
    return busy ? fb[pos] : 1'b1;
  endfunction

  function automatic string txd_req();
    if (ctx_r9) return "R9";
    if (!busy) return "R8";
    if (pos <= 8) return "R4";
    if (m_pe && pos == 9) return "R5";
    return "R6";
  endfunction

  task automatic build_frame(input logic [7:0] d, input bit pe, input bit po, input bit ts);
    fb = '1;
    fb[0] = 1'b0;
    fb[8:1] = d;
    if (pe) fb[9] = po ? ~(^d) : (^d);
    flen = 10 + int'(pe) + int'(ts);
    m_pe = pe;
    pos = 0;
  endtask

  task automatic model_step();
    int cnt;
    bit popped;
    cnt = mq.size();
    popped = 0;
    if (baud_tick) begin
      if (busy && pos < flen - 1) pos++;
      else if (cnt > 0) begin
        build_frame(mq[0], parity_en, parity_odd, two_stop);
        busy = 1;
        popped = 1;
      end else busy = 0;
    end
    if (popped) void'(mq.pop_front());
    if (wr_en) begin
      if (cnt == 8) m_ovf = 1;
      else mq.push_back(wr_data);
    end
    if (!(wr_en && cnt == 8) && ovf_clear) m_ovf = 0;
    if (8 - mq.size() >= 4) m_svc = 1;
    else if (mq.size() >= 5) m_svc = 0;
  endtask

  task automatic check_all();
    chk(txd_req(), txd, exp_txd());
    chk("R7", svc_req, m_svc);
    chk("R2", space_avail, logic'(mq.size() < 8));
    chk("R3", overflow, m_ovf);
  endtask

  task automatic cyc(input bit w, input logic [7:0] d, input bit t, input bit clr);
    wr_en = w; wr_data = d; baud_tick = t; ovf_clear = clr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 0; baud_tick = 0; ovf_clear = 0;
    check_all();
  endtask

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  always @(posedge clk) cycles++;

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", txd, 1'b1);
    chk("R1", svc_req, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", txd, 1'b1);
    chk("R1", svc_req, 1'b1);
    chk("R1", space_avail, 1'b1);
    chk("R1", overflow, 1'b0);

    // R2 R3 R7: fill past capacity with no ticks
    for (int i = 0; i < 9; i++) cyc(1, 8'h10 + 8'(i), 0, 0);
    chk("R3", overflow, 1'b1);
    chk("R2", space_avail, 1'b0);
    repeat (3) cyc(0, 0, 0, 0);
    cyc(1, 8'hEE, 0, 1);
    chk("R3", overflow, 1'b1);
    cyc(0, 0, 0, 1);
    chk("R3", overflow, 1'b0);

    // R4 R6 R8: drain back-to-back, 8N1, tick every cycle
    parity_en = 0; two_stop = 0;
    repeat (90) cyc(0, 0, 1, 0);
    chk("R8", txd, 1'b1);

    // R5 R6: odd parity, two stops, sparse ticks
    parity_en = 1; parity_odd = 1; two_stop = 1;
    cyc(1, 8'h00, 0, 0);
    cyc(1, 8'hFF, 0, 0);
    for (int i = 0; i < 30; i++) begin
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 0);
    end
    parity_odd = 0;
    cyc(1, 8'hA5, 0, 0);
    cyc(1, 8'h01, 0, 0);
    repeat (30) cyc(0, 0, 1, 0);

    // R9: change settings in mid-frame
    parity_en = 0; two_stop = 0;
    cyc(1, 8'h3C, 0, 0);
    cyc(0, 0, 1, 0);
    ctx_r9 = 1;
    parity_en = 1; parity_odd = 1; two_stop = 1;
    repeat (3) cyc(0, 0, 1, 0);
    parity_en = 0; two_stop = 0;
    repeat (12) cyc(0, 0, 1, 0);
    ctx_r9 = 0;

    // random traffic
    for (int ph = 0; ph < 4; ph++) begin
      int wprob, tprob;
      wprob = (ph == 0) ? 4 : (ph == 1) ? 30 : (ph == 2) ? 60 : 15;
      tprob = (ph == 3) ? 90 : 40;
      for (int i = 0; i < 2000; i++) begin
        if ($urandom_range(99) < 2) begin
          parity_en = 1'($urandom); parity_odd = 1'($urandom); two_stop = 1'($urandom);
        end
        cyc(1'($urandom_range(99) < wprob), 8'($urandom),
            1'($urandom_range(99) < tprob), 1'($urandom_range(99) < 3));
      end
    end
    repeat (300) cyc(0, 0, 1, 0);
    chk("R8", txd, 1'b1);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule